// File: doc/BRIEF.md
# Protected-Command NOR Flash Write Sequencer

This block is a clocked behavioural model of the write side of a NOR flash bank. It watches an asynchronous bus driven by a host: an active-low chip select, an active-low write strobe, an active-low read strobe, an address and a data word. Every strobe passes through a two-stage synchronizer before it is used. A bus write cycle opens when chip select and write strobe are both low while the read strobe is high. The block takes the address when the cycle opens, which is the falling edge of whichever strobe went low last. It takes the data when the cycle closes, which is the rising edge of whichever strobe went high first.

Completed write cycles feed a sequencer. Software must first send an unlock preamble. Only then is a word program or an erase of one sector, one block or the whole array accepted. An accepted command updates a small backing array and loads a busy timer. Until the timer runs out, the `busy` output stays high and every bus write cycle is thrown away. Reads through the read strobe return the stored word asynchronously. The status-read encoding is not part of this block.

The backing array keeps `KEEP_W` low address bits for each sector. Addresses in the same sector that share those low bits map to the same stored word.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset, `busy` is low and every address reads 16'hFFFF.
- R2: A write cycle is recognised only while chip select and write strobe are both low and the read strobe is high. Strobes given while the read strobe is low form no cycle.
- R3: The address of a cycle is the one present at the later of the two falling strobe edges. The data is the one present at the earlier of the two rising edges.
- R4: Word program is the following sequence, in order. Commands match on address bits [14:0] and data bits [7:0].
  - 8'hAA to 15'h5555
  - 8'h55 to 15'h2AAA
  - 8'hA0 to 15'h5555
  - one more cycle carrying the target address and data
  The stored word becomes the old word AND the new data.
- R5: Sector erase is the following six cycles. It sets every word whose address bits [15:11] equal those of the last cycle to 16'hFFFF. Other sectors are left unchanged.
  - 8'hAA to 15'h5555
  - 8'h55 to 15'h2AAA
  - 8'h80 to 15'h5555
  - 8'hAA to 15'h5555
  - 8'h55 to 15'h2AAA
  - 8'h30 to the sector address
- R6: Block erase is the same six cycles with 8'h50 in the last cycle. It sets every word whose address bit [15] equals that of the last cycle to 16'hFFFF. Other blocks are left unchanged.
- R7: Chip erase is the same six cycles with 8'h10 written to 15'h5555 in the last cycle. It sets the whole array to 16'hFFFF. A last cycle of 8'h10 to any other address does nothing.
- R8: A cycle that does not match the expected address and data returns the sequencer to idle. Such a cycle leaves the array unchanged and does not raise `busy`.
- R9: An accepted command raises `busy` within a few clocks. `busy` then stays high for exactly `PROG_CYC` clocks after a program, or exactly `ERASE_CYC` clocks after an erase.
- R10: Write cycles that arrive while `busy` is high are discarded. After `busy` falls, a new command must start again from the first unlock cycle.
- R11: The read data is the word stored in slot {addr[15:11], addr[1:0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_ce_n | input | 1 | Active-low chip select (asynchronous) |
| bus_we_n | input | 1 | Active-low write strobe (asynchronous) |
| bus_oe_n | input | 1 | Active-low read strobe (asynchronous) |
| bus_addr | input | AW | Word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Stored word at bus_addr |
| busy | output | 1 | High while an internal program or erase runs |

## Verification
The bound checker checks four rules on every clock:
- a command is never issued while `busy` is high;
- the sequencer sits idle throughout a busy period;
- `busy` rises only in the clock after an accepted command;
- every busy period lasts exactly the program or the erase latency.

The bench scenarios cover the rest:
- the arithmetic on stored words and the extent of each erase granularity;
- the edge on which address and data are taken when the two strobes overlap in different orders;
- the rejection of broken sequences, read-strobe-low cycles and a mis-addressed chip erase;
- the loss of a full program sequence sent during an erase.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_UNL1,
        SQ_UNL2,
        SQ_PROG,
        SQ_ERA1,
        SQ_ERA2,
        SQ_ERA3
    } seq_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_PROG,
        OP_SECT,
        OP_BLK,
        OP_CHIP
    } op_e;

    localparam logic [7:0]  K_KEY_A  = 8'hAA;
    localparam logic [7:0]  K_KEY_B  = 8'h55;
    localparam logic [7:0]  K_PROG   = 8'hA0;
    localparam logic [7:0]  K_ERASE  = 8'h80;
    localparam logic [7:0]  K_SECT   = 8'h30;
    localparam logic [7:0]  K_BLK    = 8'h50;
    localparam logic [7:0]  K_CHIP   = 8'h10;
    localparam logic [14:0] K_ADR_A  = 15'h5555;
    localparam logic [14:0] K_ADR_B  = 15'h2AAA;

endpackage

// File: rtl/nor_strobe_edge.sv
module nor_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic we_n,
    input  logic oe_n,
    output logic cyc_open,
    output logic cyc_close
);

    typedef struct packed {
        logic [1:0] ce;
        logic [1:0] we;
        logic [1:0] oe;
        logic       act;
    } strb_t;

    strb_t q, d;
    logic  act_now;

    always_comb begin
        d        = q;
        d.ce     = {q.ce[0], ce_n};
        d.we     = {q.we[0], we_n};
        d.oe     = {q.oe[0], oe_n};
        act_now  = ~q.ce[1] & ~q.we[1] & q.oe[1];
        d.act    = act_now;
        cyc_open  = act_now & ~q.act;
        cyc_close = ~act_now & q.act;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{ce: 2'b11, we: 2'b11, oe: 2'b11, act: 1'b0};
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/nor_seq_fsm.sv
module nor_seq_fsm
    import nor_cmd_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cyc_close,
    input  logic          busy,
    input  logic [AW-1:0] c_addr,
    input  logic [DW-1:0] c_data,
    output op_e           op,
    output logic [AW-1:0] op_addr,
    output logic [DW-1:0] op_data,
    output logic          seq_idle
);

    typedef struct packed {
        seq_e st;
    } fsm_t;

    fsm_t q, d;
    logic at_a, at_b;
    logic [7:0] code;

    always_comb begin
        d       = q;
        op      = OP_NONE;
        op_addr = c_addr;
        op_data = c_data;
        at_a    = (c_addr[14:0] == K_ADR_A);
        at_b    = (c_addr[14:0] == K_ADR_B);
        code    = c_data[7:0];
        if (busy) begin
            d.st = SQ_IDLE;
        end else if (cyc_close) begin
            d.st = SQ_IDLE;
            unique case (q.st)
                SQ_IDLE: if (at_a && code == K_KEY_A) d.st = SQ_UNL1;
                SQ_UNL1: if (at_b && code == K_KEY_B) d.st = SQ_UNL2;
                SQ_UNL2: begin
                    if (at_a && code == K_PROG)  d.st = SQ_PROG;
                    if (at_a && code == K_ERASE) d.st = SQ_ERA1;
                end
                SQ_PROG: op = OP_PROG;
                SQ_ERA1: if (at_a && code == K_KEY_A) d.st = SQ_ERA2;
                SQ_ERA2: if (at_b && code == K_KEY_B) d.st = SQ_ERA3;
                SQ_ERA3: begin
                    if (code == K_SECT)         op = OP_SECT;
                    if (code == K_BLK)          op = OP_BLK;
                    if (code == K_CHIP && at_a) op = OP_CHIP;
                end
                default: d.st = SQ_IDLE;
            endcase
        end
        seq_idle = (q.st == SQ_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st <= SQ_IDLE;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/nor_busy_timer.sv
module nor_busy_timer #(
    parameter int PROG_CYC  = 64,
    parameter int ERASE_CYC = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic is_prog,
    output logic busy
);

    localparam int LAT_MAX = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int CW      = $clog2(LAT_MAX + 1);
    localparam logic [CW-1:0] P_LD = CW'(PROG_CYC);
    localparam logic [CW-1:0] E_LD = CW'(ERASE_CYC);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d = q;
        if (start) begin
            d.cnt = is_prog ? P_LD : E_LD;
        end else if (q.cnt != '0) begin
            d.cnt = q.cnt - 1'b1;
        end
        busy = (q.cnt != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cnt <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_cmd_pkg::*;
#(
    parameter int AW        = 16,
    parameter int DW        = 16,
    parameter int SECT_LSB  = 11,
    parameter int BLK_LSB   = 15,
    parameter int KEEP_W    = 2,
    parameter int PROG_CYC  = 64,
    parameter int ERASE_CYC = 300
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_ce_n,
    input  logic          bus_we_n,
    input  logic          bus_oe_n,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          busy
);

    localparam int IDX_W     = AW - SECT_LSB + KEEP_W;
    localparam int NW        = 1 << IDX_W;
    localparam int BLK_SHIFT = KEEP_W + BLK_LSB - SECT_LSB;

    typedef struct packed {
        logic [AW-1:0]          addr;
        logic [NW-1:0][DW-1:0]  mem;
    } arr_t;

    arr_t q, d;

    logic          cyc_open, cyc_close;
    op_e           op;
    logic [AW-1:0] op_addr;
    logic [DW-1:0] op_data;
    logic          seq_idle;
    logic          op_go;

    function automatic logic [IDX_W-1:0] slot_of(input logic [AW-1:0] a);
        return {a[AW-1:SECT_LSB], a[KEEP_W-1:0]};
    endfunction

    nor_strobe_edge u_strb (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (bus_ce_n),
        .we_n     (bus_we_n),
        .oe_n     (bus_oe_n),
        .cyc_open (cyc_open),
        .cyc_close(cyc_close)
    );

    nor_seq_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cyc_close(cyc_close),
        .busy     (busy),
        .c_addr   (q.addr),
        .c_data   (bus_wdata),
        .op       (op),
        .op_addr  (op_addr),
        .op_data  (op_data),
        .seq_idle (seq_idle)
    );

    assign op_go = (op != OP_NONE);

    nor_busy_timer #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (op_go),
        .is_prog(op == OP_PROG),
        .busy   (busy)
    );

    always_comb begin
        d = q;
        if (cyc_open) begin
            d.addr = bus_addr;
        end
        unique case (op)
            OP_PROG: d.mem[slot_of(op_addr)] = q.mem[slot_of(op_addr)] & op_data;
            OP_SECT: begin
                for (int i = 0; i < NW; i++) begin
                    if ((i >> KEEP_W) == int'(op_addr[AW-1:SECT_LSB])) d.mem[i] = '1;
                end
            end
            OP_BLK: begin
                for (int i = 0; i < NW; i++) begin
                    if ((i >> BLK_SHIFT) == int'(op_addr[AW-1:BLK_LSB])) d.mem[i] = '1;
                end
            end
            OP_CHIP: d.mem = '1;
            default: ;
        endcase
        bus_rdata = q.mem[slot_of(bus_addr)];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.addr <= '0;
            q.mem  <= '1;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/nor_cmd_chk.sv
module nor_cmd_chk #(
    parameter int PROG_CYC  = 64,
    parameter int ERASE_CYC = 300
) (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic op_go,
    input logic seq_idle
);

    localparam int LAT_MAX = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;

    int run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run <= 0;
        else        run <= busy ? run + 1 : 0;
    end

    // R10: nothing is issued while an operation runs
    a_r10_no_issue_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !op_go);

    // R10: sequencer restarts from idle throughout a busy period
    a_r10_seq_idle_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> seq_idle);

    // R9: an accepted command raises busy next cycle
    a_r9_go_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        op_go |=> busy);

    // R9: busy only rises after an accepted command
    a_r9_rise_from_go: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(op_go));

    // R9: busy period length is one of the two latencies
    a_r9_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run == PROG_CYC || run == ERASE_CYC));

    // R9: busy never exceeds the longest latency
    a_r9_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run <= LAT_MAX);

endmodule

bind nor_cmd_seq nor_cmd_chk #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .op_go   (op_go),
    .seq_idle(seq_idle)
);

// File: tb/nor_cmd_seq_tb.sv
module nor_cmd_seq_tb;

    localparam int PROG_CYC  = 64;
    localparam int ERASE_CYC = 300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [15:0] addr = '0, wdata = '0;
    logic [15:0] rdata;
    logic        busy;

    int checks = 0;
    int errors = 0;
    int hi_cnt = 0;
    int last_run = 0;
    bit done = 0;

    always #5 clk = ~clk;

    nor_cmd_seq #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_ce_n(ce_n), .bus_we_n(we_n), .bus_oe_n(oe_n),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .busy(busy)
    );

    always @(negedge clk) begin
        if (busy) hi_cnt = hi_cnt + 1;
        else begin
            if (hi_cnt > 0) last_run = hi_cnt;
            hi_cnt = 0;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] dv);
        @(negedge clk); addr = a; wdata = dv; ce_n = 1'b0;
        @(negedge clk); we_n = 1'b0;
        repeat (5) @(negedge clk);
        we_n = 1'b1;
        repeat (5) @(negedge clk);
        ce_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic wr_oe_low(input logic [15:0] a, input logic [15:0] dv);
        @(negedge clk); addr = a; wdata = dv; oe_n = 1'b0; ce_n = 1'b0;
        @(negedge clk); we_n = 1'b0;
        repeat (5) @(negedge clk);
        we_n = 1'b1;
        repeat (5) @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    // write strobe falls first with a wrong address; chip select falls last
    // with the real one; chip select rises first, then data goes bad
    task automatic wr_skew(input logic [15:0] bad_a, input logic [15:0] a,
                           input logic [15:0] dv, input logic [15:0] bad_d);
        @(negedge clk); addr = bad_a; wdata = dv; we_n = 1'b0;
        repeat (4) @(negedge clk);
        addr = a;
        @(negedge clk); ce_n = 1'b0;
        repeat (5) @(negedge clk);
        ce_n = 1'b1;
        repeat (5) @(negedge clk);
        wdata = bad_d;
        repeat (2) @(negedge clk);
        we_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic rd_chk(input string req, input logic [15:0] a, input logic [15:0] exp);
        @(negedge clk); addr = a; oe_n = 1'b0;
        #1;
        check(req, {16'h0, rdata}, {16'h0, exp});
        oe_n = 1'b1;
    endtask

    task automatic unlock_prog(input logic [15:0] a, input logic [15:0] dv);
        wr(16'h5555, 16'h00AA);
        wr(16'h2AAA, 16'h0055);
        wr(16'h5555, 16'h00A0);
        wr(a, dv);
    endtask

    task automatic erase_cmd(input logic [15:0] a, input logic [7:0] cmd);
        wr(16'h5555, 16'h00AA);
        wr(16'h2AAA, 16'h0055);
        wr(16'h5555, 16'h0080);
        wr(16'h5555, 16'h00AA);
        wr(16'h2AAA, 16'h0055);
        wr(a, {8'h00, cmd});
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 busy after reset", {31'h0, busy}, 32'h0);
        rd_chk("R1 erased word", 16'h0003, 16'hFFFF);
        rd_chk("R1 erased word", 16'h8001, 16'hFFFF);
    endtask

    task automatic t_program();
        unlock_prog(16'h0003, 16'h1234);
        check("R9 busy after program", {31'h0, busy}, 32'h1);
        wait_idle();
        check("R9 program busy length", last_run, PROG_CYC);
        rd_chk("R4 programmed word", 16'h0003, 16'h1234);
        unlock_prog(16'h0003, 16'hFF0F);
        wait_idle();
        rd_chk("R4 program ANDs old word", 16'h0003, 16'h1204);
        rd_chk("R11 alias slot in sector", 16'h0403, 16'h1204);
    endtask

    task automatic t_broken();
        wr(16'h5555, 16'h00AA);
        wr(16'h2AAB, 16'h0055);
        wr(16'h5555, 16'h00A0);
        wr(16'h0001, 16'h0000);
        check("R8 no busy on broken sequence", {31'h0, busy}, 32'h0);
        rd_chk("R8 array unchanged", 16'h0001, 16'hFFFF);
    endtask

    task automatic t_oe_low();
        wr_oe_low(16'h5555, 16'h00AA);
        wr(16'h2AAA, 16'h0055);
        wr(16'h5555, 16'h00A0);
        wr(16'h0002, 16'h0000);
        check("R2 no busy with read strobe low", {31'h0, busy}, 32'h0);
        rd_chk("R2 read-strobe-low cycle ignored", 16'h0002, 16'hFFFF);
    endtask

    task automatic t_skew();
        wr(16'h5555, 16'h00AA);
        wr(16'h2AAA, 16'h0055);
        wr(16'h5555, 16'h00A0);
        wr_skew(16'h0C02, 16'h0801, 16'h5A5A, 16'h0000);
        wait_idle();
        rd_chk("R3 address at last fall", 16'h0801, 16'h5A5A);
        rd_chk("R3 early address unused", 16'h0C02, 16'hFFFF);
    endtask

    task automatic t_sector_and_ignore();
        unlock_prog(16'h1802, 16'h1111); wait_idle();
        unlock_prog(16'h2002, 16'h2222); wait_idle();
        erase_cmd(16'h1800, 8'h30);
        unlock_prog(16'h2003, 16'h0000);
        unlock_prog(16'h2002, 16'h0000);
        check("R10 still busy during discarded writes", {31'h0, busy}, 32'h1);
        wait_idle();
        check("R9 erase busy length", last_run, ERASE_CYC);
        rd_chk("R5 sector erased", 16'h1802, 16'hFFFF);
        rd_chk("R5 other sector kept", 16'h2002, 16'h2222);
        rd_chk("R10 write during busy discarded", 16'h2003, 16'hFFFF);
        unlock_prog(16'h2003, 16'h00FF); wait_idle();
        rd_chk("R10 fresh sequence after busy", 16'h2003, 16'h00FF);
    endtask

    task automatic t_block();
        unlock_prog(16'h8001, 16'h3333); wait_idle();
        erase_cmd(16'h8000, 8'h50);
        wait_idle();
        rd_chk("R6 block erased", 16'h8001, 16'hFFFF);
        rd_chk("R6 other block kept", 16'h2002, 16'h2222);
        rd_chk("R6 other block kept", 16'h0003, 16'h1204);
    endtask

    task automatic t_chip();
        erase_cmd(16'h1234, 8'h10);
        check("R7 misaddressed chip erase no busy", {31'h0, busy}, 32'h0);
        rd_chk("R7 misaddressed chip erase ignored", 16'h2002, 16'h2222);
        erase_cmd(16'h5555, 8'h10);
        wait_idle();
        check("R9 chip erase busy length", last_run, ERASE_CYC);
        rd_chk("R7 chip erased", 16'h2002, 16'hFFFF);
        rd_chk("R7 chip erased", 16'h0003, 16'hFFFF);
        rd_chk("R7 chip erased", 16'h0801, 16'hFFFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_program();
        t_broken();
        t_oe_low();
        t_skew();
        t_sector_and_ignore();
        t_block();
        t_chip();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule